// File: doc/BRIEF.md
# DRAM Training Command Sequencer

This block lets a memory-training routine push a short list of raw DRAM commands onto the command bus without the normal scheduler. Software fills up to four queue slots through a single-cycle register write port. Each slot holds a row/column address, a bank, a slot-rank select, the three active-low command strobes, and a post-command cooldown measured in clock cycles. A write to the control register sets the command count and can set the start bit.

Once started, the sequencer issues the slots in index order. Each command appears on the output bus for one cycle with a valid strobe. After each command the sequencer waits for that slot's cooldown before it issues the next slot. `busy` covers the whole run. A one-cycle `done` pulse marks its end. While a run is in progress, all register writes are ignored, including new start requests.

Register word map on `wr_addr`:
- Words 0 to 3: location word of slots 0 to 3.
- Words 4 to 7: strobe byte of slots 0 to 3.
- Words 8 to 11: cooldown word of slots 0 to 3.
- Word 12: control register.

Top module: `dram_train_cmdq`

## Requirements
- R1: After reset the bus is idle: `cmd_valid`=0, all three strobes are 1 (NOP), and `busy` and `done` are both 0.
- R2: The location word carries the address in bits 15:0, the bank in bits 22:20 and the slot-rank in bits 25:24. These values appear on `cmd_addr`, `cmd_bank` and `cmd_rank` when the slot issues.
- R3: The strobe byte carries RAS in bit 0, CAS in bit 1 and WE in bit 2. They are driven unchanged, active low, on `cmd_ras_n`, `cmd_cas_n` and `cmd_we_n`.
- R4: Control bits 19:16 hold (N-1)*4. The values 0, 4, 8 and 12 run exactly 1, 2, 3 and 4 commands.
- R5: Slots issue in order 0..N-1. Each command is valid for exactly one cycle, and the strobes read 111 whenever `cmd_valid` is low.
- R6: If slot k issues in cycle T and its cooldown (bits 31:16 of its cooldown word) is W, slot k+1 issues in cycle T+1+W. A cooldown of 0 gives back-to-back commands.
- R7: Suppose a control write with bit 0 set is captured at clock edge P. Then `busy` is high from the cycle after P, the first command issues one cycle later, and `done` pulses for one cycle, with `busy` low, W+1 cycles after the last command's cycle (W being the last slot's cooldown).
- R8: Writes to queue slots while `busy` is high leave the slots unchanged.
- R9: A start request while `busy` is high is dropped. It neither lengthens the run nor changes the count used by the run.
- R10: Bits 17:16 of the count field are ignored: 9 runs 3 commands and 6 runs 2 commands.
- R11: The start bit acts once per write. A control write with bit 0 clear starts nothing, and one start write produces exactly one run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word index |
| wr_data | input | 32 | Register write data |
| cmd_valid | output | 1 | Command on the bus this cycle |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write-enable strobe, active low |
| cmd_addr | output | 16 | Row/column address |
| cmd_bank | output | 3 | Bank address |
| cmd_rank | output | 2 | Slot-rank select |
| busy | output | 1 | Queue run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Several properties are checked on every cycle:
- The bus shows NOP whenever it is not valid, and a command appears only while busy.
- The cooldown counter steps down by one per cycle after each load.
- The slot index stays within the programmed count.
- Locked slots and the latched count hold still during a run.
- `done` is a single pulse that falls outside busy.

Other behaviour only the scenarios can show, because it needs a model of what was programmed: the exact issue cycle of each slot for mixed cooldowns, the field placement on the bus, the count decoding including ignored low bits, and the effect of a dropped start or of writes made during a run.

// File: rtl/tq_pkg.sv
package tq_pkg;

  localparam int ROW_W  = 16;
  localparam int BANK_W = 3;
  localparam int RANK_W = 2;
  localparam int COOL_W = 16;

  // bit positions inside the written words
  localparam int LOC_LSB   = 0;
  localparam int BANK_LSB  = 20;
  localparam int RANK_LSB  = 24;
  localparam int COOL_LSB  = 16;
  localparam int CNT_LSB   = 16;
  localparam int START_BIT = 0;

  typedef struct packed {
    logic [ROW_W-1:0]  loc;
    logic [BANK_W-1:0] bank;
    logic [RANK_W-1:0] rank;
    logic              we_n;
    logic              cas_n;
    logic              ras_n;
    logic [COOL_W-1:0] cool;
  } ent_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2,
    SQ_DONE  = 2'd3
  } sq_state_t;

  function automatic logic [ROW_W-1:0] loc_of(input logic [31:0] w);
    return w[LOC_LSB +: ROW_W];
  endfunction

  function automatic logic [BANK_W-1:0] bank_of(input logic [31:0] w);
    return w[BANK_LSB +: BANK_W];
  endfunction

  function automatic logic [RANK_W-1:0] rank_of(input logic [31:0] w);
    return w[RANK_LSB +: RANK_W];
  endfunction

  function automatic logic [COOL_W-1:0] cool_of(input logic [31:0] w);
    return w[COOL_LSB +: COOL_W];
  endfunction

  // count code is (N-1)*4; the two low bits carry nothing
  function automatic int unsigned last_of_code(input logic [31:0] w);
    logic [3:0] code;
    code = w[CNT_LSB +: 4];
    return int'(code) >> 2;
  endfunction

endpackage

// File: rtl/tq_regfile.sv
module tq_regfile #(
  parameter int NUM_ENT = 4,
  parameter int AW      = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [31:0]                wr_data,
  input  logic                       lock,
  output tq_pkg::ent_t [NUM_ENT-1:0] ents
);
  import tq_pkg::*;

  localparam int LOC_BASE  = 0;
  localparam int STB_BASE  = NUM_ENT;
  localparam int COOL_BASE = 2 * NUM_ENT;

  localparam ent_t ENT_RST = '{loc: '0, bank: '0, rank: '0,
                               we_n: 1'b1, cas_n: 1'b1, ras_n: 1'b1,
                               cool: '0};

  ent_t ent_q [NUM_ENT];
  logic wr_ok;

  assign wr_ok = wr_en && !lock;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_slot
    logic hit_loc, hit_stb, hit_cool;
    assign hit_loc  = wr_ok && (wr_addr == AW'(LOC_BASE + i));
    assign hit_stb  = wr_ok && (wr_addr == AW'(STB_BASE + i));
    assign hit_cool = wr_ok && (wr_addr == AW'(COOL_BASE + i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[i] <= ENT_RST;
      end else begin
        if (hit_loc) begin
          ent_q[i].loc  <= loc_of(wr_data);
          ent_q[i].bank <= bank_of(wr_data);
          ent_q[i].rank <= rank_of(wr_data);
        end
        if (hit_stb) begin
          ent_q[i].ras_n <= wr_data[0];
          ent_q[i].cas_n <= wr_data[1];
          ent_q[i].we_n  <= wr_data[2];
        end
        if (hit_cool) begin
          ent_q[i].cool <= cool_of(wr_data);
        end
      end
    end

    assign ents[i] = ent_q[i];

    // R8: a write during a run leaves the slot untouched
    p_locked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && wr_en) |=> $stable(ent_q[i]));
  end

endmodule

// File: rtl/tq_wait_ctr.sv
module tq_wait_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // last cooldown cycle: counter is about to reach zero
  assign expire = (cnt_q == CW'(1));

  // R6: cooldown counts down by one each cycle after load
  p_wait_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_wait_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/tq_seq_fsm.sv
module tq_seq_fsm #(
  parameter int NUM_ENT = 4,
  parameter int IDXW    = 2,
  parameter int CW      = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_wr,
  input  logic            start_bit,
  input  logic [IDXW-1:0] ctrl_last,
  input  logic [CW-1:0]   cur_cool,
  input  logic            expire,
  output logic            issue_fire,
  output logic [IDXW-1:0] idx,
  output logic            busy,
  output logic            done
);
  import tq_pkg::*;

  sq_state_t       state_q;
  logic [IDXW-1:0] idx_q;
  logic [IDXW-1:0] last_q;
  logic            done_q;
  logic            at_last;
  logic            step;

  assign issue_fire = (state_q == SQ_ISSUE);
  assign at_last    = (idx_q == last_q);
  assign step       = (issue_fire && cur_cool == '0) ||
                      (state_q == SQ_WAIT && expire);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      last_q  <= IDXW'(NUM_ENT - 1);
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (ctrl_wr) begin
            last_q <= ctrl_last;
            if (start_bit) begin
              state_q <= SQ_ISSUE;
              idx_q   <= '0;
            end
          end
        end
        SQ_ISSUE, SQ_WAIT: begin
          if (step) begin
            if (at_last) begin
              state_q <= SQ_DONE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= SQ_ISSUE;
            end
          end else if (issue_fire) begin
            state_q <= SQ_WAIT;
          end
        end
        SQ_DONE: begin
          state_q <= SQ_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign idx  = idx_q;
  assign busy = (state_q != SQ_IDLE);
  assign done = done_q;

  // R5: index never runs past the programmed count
  p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q <= last_q));

  // R5: every run begins at slot 0
  p_first_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (idx_q == '0));

  // R7: done is a lone pulse outside busy
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: a start or count write during a run has no effect
  p_start_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr) |=> $stable(last_q));

endmodule

// File: rtl/tq_cmd_drive.sv
module tq_cmd_drive #(
  parameter int AWD = 16,
  parameter int BW  = 3,
  parameter int RW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic [AWD-1:0] in_addr,
  input  logic [BW-1:0]  in_bank,
  input  logic [RW-1:0]  in_rank,
  input  logic           in_ras_n,
  input  logic           in_cas_n,
  input  logic           in_we_n,
  output logic           cmd_valid,
  output logic           cmd_ras_n,
  output logic           cmd_cas_n,
  output logic           cmd_we_n,
  output logic [AWD-1:0] cmd_addr,
  output logic [BW-1:0]  cmd_bank,
  output logic [RW-1:0]  cmd_rank
);

  always_ff @(posedge clk) begin
    if (!rst_n || !fire) begin
      cmd_valid <= 1'b0;
      cmd_ras_n <= 1'b1;
      cmd_cas_n <= 1'b1;
      cmd_we_n  <= 1'b1;
      cmd_addr  <= '0;
      cmd_bank  <= '0;
      cmd_rank  <= '0;
    end else begin
      cmd_valid <= 1'b1;
      cmd_ras_n <= in_ras_n;
      cmd_cas_n <= in_cas_n;
      cmd_we_n  <= in_we_n;
      cmd_addr  <= in_addr;
      cmd_bank  <= in_bank;
      cmd_rank  <= in_rank;
    end
  end

  // R5: idle bus shows NOP
  p_nop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (cmd_ras_n && cmd_cas_n && cmd_we_n));

endmodule

// File: rtl/dram_train_cmdq.sv
module dram_train_cmdq #(
  parameter  int NUM_ENT = 4,
  localparam int AW      = $clog2(3 * NUM_ENT + 1),
  localparam int IDXW    = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  output logic          cmd_valid,
  output logic          cmd_ras_n,
  output logic          cmd_cas_n,
  output logic          cmd_we_n,
  output logic [15:0]   cmd_addr,
  output logic [2:0]    cmd_bank,
  output logic [1:0]    cmd_rank,
  output logic          busy,
  output logic          done
);
  import tq_pkg::*;

  localparam int CTRL_WORD = 3 * NUM_ENT;

  ent_t [NUM_ENT-1:0] ents;
  ent_t               cur;
  logic               ctrl_wr;
  logic [IDXW-1:0]    ctrl_last;
  logic [IDXW-1:0]    idx;
  logic               issue_fire;
  logic               expire;

  assign ctrl_wr   = wr_en && (wr_addr == AW'(CTRL_WORD));
  assign ctrl_last = IDXW'(last_of_code(wr_data));

  tq_regfile #(.NUM_ENT(NUM_ENT), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .lock    (busy),
    .ents    (ents)
  );

  assign cur = ents[idx];

  tq_seq_fsm #(.NUM_ENT(NUM_ENT), .IDXW(IDXW), .CW(COOL_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .start_bit  (wr_data[START_BIT]),
    .ctrl_last  (ctrl_last),
    .cur_cool   (cur.cool),
    .expire     (expire),
    .issue_fire (issue_fire),
    .idx        (idx),
    .busy       (busy),
    .done       (done)
  );

  tq_wait_ctr #(.CW(COOL_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issue_fire),
    .load_val (cur.cool),
    .expire   (expire)
  );

  tq_cmd_drive #(.AWD(ROW_W), .BW(BANK_W), .RW(RANK_W)) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (issue_fire),
    .in_addr   (cur.loc),
    .in_bank   (cur.bank),
    .in_rank   (cur.rank),
    .in_ras_n  (cur.ras_n),
    .in_cas_n  (cur.cas_n),
    .in_we_n   (cur.we_n),
    .cmd_valid (cmd_valid),
    .cmd_ras_n (cmd_ras_n),
    .cmd_cas_n (cmd_cas_n),
    .cmd_we_n  (cmd_we_n),
    .cmd_addr  (cmd_addr),
    .cmd_bank  (cmd_bank),
    .cmd_rank  (cmd_rank)
  );

  // R7: commands only appear inside a run
  p_valid_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);

  // R7: done closes a run
  p_done_after_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

endmodule

// File: tb/tb_dram_train_cmdq.sv
module tb_dram_train_cmdq;

  typedef struct {
    int          cyc;
    logic [15:0] a;
    logic [2:0]  b;
    logic [1:0]  r;
    logic [2:0]  s;   // {we,cas,ras}
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        cmd_valid, cmd_ras_n, cmd_cas_n, cmd_we_n, busy, done;
  logic [15:0] cmd_addr;
  logic [2:0]  cmd_bank;
  logic [1:0]  cmd_rank;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int busy_lo = 1, busy_hi = 0, done_at = -1;
  bit fin = 0;
  string cur_tag = "";
  exp_t expq[$];
  exp_t e;

  int m_a[4], m_b[4], m_r[4], m_s[4], m_w[4];

  always #10 clk = ~clk;   // 50 MHz

  dram_train_cmdq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
    .cmd_we_n(cmd_we_n), .cmd_addr(cmd_addr), .cmd_bank(cmd_bank),
    .cmd_rank(cmd_rank), .busy(busy), .done(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", cur_tag, tag, act, exp, cyc);
    end
  endtask

  // monitor: compare the bus against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk(busy == (cyc >= busy_lo && cyc <= busy_hi), "R7 busy window", busy,
          (cyc >= busy_lo && cyc <= busy_hi));
      chk(done == (cyc == done_at), "R7 done pulse", done, (cyc == done_at));
      if (cmd_valid) begin
        if (expq.size() == 0) begin
          chk(0, "R5 unexpected command", 1, 0);
        end else begin
          e = expq.pop_front();
          chk(cyc == e.cyc, "R6 issue cycle", cyc, e.cyc);
          chk(cmd_addr == e.a, "R2 address", cmd_addr, e.a);
          chk(cmd_bank == e.b, "R2 bank", cmd_bank, e.b);
          chk(cmd_rank == e.r, "R2 rank", cmd_rank, e.r);
          chk({cmd_we_n, cmd_cas_n, cmd_ras_n} == e.s, "R3 strobes",
              {cmd_we_n, cmd_cas_n, cmd_ras_n}, e.s);
        end
      end else begin
        chk({cmd_we_n, cmd_cas_n, cmd_ras_n} == 3'b111, "R5 NOP when idle",
            {cmd_we_n, cmd_cas_n, cmd_ras_n}, 7);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic prog(input int i, input int a, input int b, input int r,
                      input int s, input int w);
    wr(i,     (r << 24) | (b << 20) | a);
    wr(4 + i, s);
    wr(8 + i, w << 16);
    m_a[i] = a; m_b[i] = b; m_r[i] = r; m_s[i] = s; m_w[i] = w;
  endtask

  // driver: start a run and push the expected commands
  task automatic launch(input int code);
    int p, n, t;
    exp_t x;
    p = cyc + 1;
    n = ((code >> 2) & 3) + 1;
    t = p + 1;
    for (int k = 0; k < n; k++) begin
      x.cyc = t; x.a = 16'(m_a[k]); x.b = 3'(m_b[k]); x.r = 2'(m_r[k]); x.s = 3'(m_s[k]);
      expq.push_back(x);
      if (k < n - 1) t = t + 1 + m_w[k];
    end
    done_at = t + m_w[n-1] + 1;
    busy_lo = p;
    busy_hi = done_at - 1;
    wr(12, 32'(1 | (code << 16)));
  endtask

  task automatic finish_run(input string tag);
    while (cyc <= done_at) @(negedge clk);
    chk(expq.size() == 0, {tag, " command count"}, expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired: actual hang expected completion");
    fin = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(cmd_valid == 0, "R1 valid", cmd_valid, 0);
    chk({cmd_we_n, cmd_cas_n, cmd_ras_n} == 3'b111, "R1 NOP", {cmd_we_n, cmd_cas_n, cmd_ras_n}, 7);
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);

    // four slots, mixed cooldowns; R4 code 12 -> 4 commands
    cur_tag = "full";
    prog(0, 16'h1234, 5, 2, 3'b110, 0);
    prog(1, 16'hABCD, 3, 1, 3'b101, 2);
    prog(2, 16'hFFFF, 7, 3, 3'b001, 0);
    prog(3, 16'h0400, 0, 0, 3'b010, 5);
    launch(12);
    finish_run("R4 code12");

    // R4 code 0 -> 1 command, with cooldown on it
    cur_tag = "single";
    prog(0, 16'h0055, 1, 1, 3'b011, 3);
    launch(0);
    finish_run("R4 code0");
    launch(8);
    finish_run("R4 code8");

    // R10 low bits ignored
    cur_tag = "R10";
    launch(9);
    finish_run("R10 code9");
    launch(6);
    finish_run("R10 code6");

    // R8 / R9: writes and restart during a run
    cur_tag = "busy-writes";
    prog(0, 16'h0F0F, 2, 3, 3'b100, 10);
    prog(1, 16'h7777, 6, 0, 3'b000, 10);
    launch(4);
    wr(0, 32'h0);
    wr(4, 32'h7);
    wr(8, 32'h0);
    wr(12, 32'h000C_0001);   // dropped start (R9)
    finish_run("R9 dropped start");
    cur_tag = "R8";
    launch(4);
    finish_run("R8 slots kept");

    // R6 long cooldown between two commands
    cur_tag = "R6 long";
    prog(0, 16'h2222, 4, 2, 3'b110, 300);
    launch(4);
    finish_run("R6 long wait");

    // R11: control write without start bit starts nothing
    cur_tag = "R11";
    wr(12, 32'h000C_0000);
    repeat (20) @(negedge clk);
    chk(expq.size() == 0 && busy == 0, "R11 no run", busy, 0);
    launch(0);
    finish_run("R11 single run");
    repeat (10) @(negedge clk);

    fin = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule